// File: doc/BRIEF.md
# Single-to-Dual Pixel Splitter

This block takes a video stream that carries one RGB pixel per clock, together with its horizontal sync, vertical sync and data-enable qualifier. It regroups the active pixels into pairs for a display link that moves two pixels per word. Each output word holds a first (odd) pixel and a second (even) pixel, each 24 bits wide. A one-cycle pair-valid strobe marks each word, so words arrive at half the input pixel rate.

Pairing restarts on every rising edge of the data-enable input, so the first active pixel of each line always lands in the odd slot. The design relies on every blanking interval lasting an even number of input cycles. If a line ends with an unpaired pixel, that pixel is emitted alone and a sticky error flag is raised. A mode input reduces every colour to its six most significant bits, for panels that take 6 bits per colour.

Top module: `pix_pair_splitter`

## Requirements
- R1: A synchronous active-high reset clears every output to zero: pair words, pair-valid, output data enable, both syncs and the error flag. The next active pixel after reset goes to the odd slot.
- R2: While data enable is high, active pixels alternate odd, even, odd, even. pairValid rises in the cycle after the clock edge that samples the even pixel, and it is never high in two consecutive cycles.
- R3: The first pixel sampled with data enable high after a low cycle always occupies the odd slot of the next pair.
- R4: In every cycle where pairValid is low, both pair words are zero and outDe is low. When pairValid is high, outDe is high.
- R5: With narrowMode low, each pixel word is laid out as red in bits 23:16, green in bits 15:8 and blue in bits 7:0, copied unchanged from the input word of the same layout.
- R6: With narrowMode high, each colour field of the output pixel carries input colour bits 7:2 in its bits 5:0, with its bits 7:6 zero. The mode is sampled together with each pixel.
- R7: In a cycle where pairValid is high, outHsync and outVsync equal the values sampled with that pair's odd pixel. In all other cycles they equal the sync inputs delayed by one clock.
- R8: When data enable is sampled low while only the odd slot is filled, the odd pixel is emitted alone in the next cycle with a zero even word. oddLineErr then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| narrowMode | input | 1 | 1 selects 6 bits per colour output |
| inDe | input | 1 | Input data enable, high on active pixels |
| inHsync | input | 1 | Input horizontal sync |
| inVsync | input | 1 | Input vertical sync |
| inPixel | input | 24 | Input pixel {red, green, blue} |
| outOdd | output | 24 | First pixel of the pair |
| outEven | output | 24 | Second pixel of the pair |
| pairValid | output | 1 | One-cycle strobe for each emitted pair |
| outDe | output | 1 | Output data enable |
| outHsync | output | 1 | Output horizontal sync |
| outVsync | output | 1 | Output vertical sync |
| oddLineErr | output | 1 | Sticky flag for a line that ended with an unpaired pixel |

## Verification
The bench builds the block with its default parameters: 8-bit colours, of which the narrow form drops the two lowest. At these values both output formats can be checked bit for bit, including a mode change between the odd and even pixel of one pair. The bench drives even-length lines, odd-length lines that force a lone odd pixel, and sync toggles placed on odd and on even pixels. Randomised lines separated by even blanking show that pairing realigns on each new line and that the error flag holds until a second reset.

// File: rtl/pix_pair_pkg.sv
package pix_pair_pkg;
  // Strobes from the control to the datapath, one decision per input cycle
  typedef struct packed {
    logic loadOdd;      // capture the current pixel into the odd slot
    logic emitFull;     // current pixel completes a pair
    logic emitPartial;  // line ended with only the odd slot filled
  } pair_ctl_t;
endpackage

// File: rtl/pix_fmt.sv
module pix_fmt #(
  parameter int COLOR_W = 8,
  parameter int DROP_W  = 2
) (
  input  logic                 narrow,
  input  logic [3*COLOR_W-1:0] pixIn,
  output logic [3*COLOR_W-1:0] pixOut
);
  localparam int KEEP_W = COLOR_W - DROP_W;

  for (genvar c = 0; c < 3; c++) begin : g_color
    logic [COLOR_W-1:0] full;
    logic [COLOR_W-1:0] reduced;
    assign full    = pixIn[c*COLOR_W +: COLOR_W];
    assign reduced = {{DROP_W{1'b0}}, full[COLOR_W-1 -: KEEP_W]};
    assign pixOut[c*COLOR_W +: COLOR_W] = narrow ? reduced : full;
  end
endmodule

// File: rtl/pair_ctrl.sv
module pair_ctrl
  import pix_pair_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inDe,
  output pair_ctl_t ctl,
  output logic      oddLineErr
);
  logic oddFilled;
  logic deQ;
  logic deRise;

  always_comb begin
    deRise          = inDe & ~deQ;
    ctl.loadOdd     = inDe & (~oddFilled | deRise);
    ctl.emitFull    = inDe & oddFilled & ~deRise;
    ctl.emitPartial = ~inDe & oddFilled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oddFilled  <= 1'b0;
      deQ        <= 1'b0;
      oddLineErr <= 1'b0;
    end else begin
      oddFilled <= ctl.loadOdd;
      deQ       <= inDe;
      if (ctl.emitPartial) oddLineErr <= 1'b1;
    end
  end

  // R2: at most one decision per cycle
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.loadOdd, ctl.emitFull, ctl.emitPartial}));

  // R3: a new line never completes a pair on its first pixel
  p_rise_starts_odd_r3: assert property (@(posedge clk) disable iff (rst)
    (inDe && !deQ) |=> (oddFilled || !inDe));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    oddLineErr |=> oddLineErr);
endmodule

// File: rtl/pair_datapath.sv
module pair_datapath
  import pix_pair_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  pair_ctl_t        ctl,
  input  logic [PIX_W-1:0] pix,
  input  logic             inHsync,
  input  logic             inVsync,
  output logic [PIX_W-1:0] outOdd,
  output logic [PIX_W-1:0] outEven,
  output logic             pairValid,
  output logic             outDe,
  output logic             outHsync,
  output logic             outVsync
);
  logic [PIX_W-1:0] holdOdd;
  logic             holdHs;
  logic             holdVs;
  logic             emit;

  assign emit = ctl.emitFull | ctl.emitPartial;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdOdd   <= '0;
      holdHs    <= 1'b0;
      holdVs    <= 1'b0;
      outOdd    <= '0;
      outEven   <= '0;
      pairValid <= 1'b0;
      outDe     <= 1'b0;
      outHsync  <= 1'b0;
      outVsync  <= 1'b0;
    end else begin
      if (ctl.loadOdd) begin
        holdOdd <= pix;
        holdHs  <= inHsync;
        holdVs  <= inVsync;
      end
      pairValid <= emit;
      outDe     <= emit;
      outOdd    <= emit ? holdOdd : '0;
      outEven   <= ctl.emitFull ? pix : '0;
      outHsync  <= emit ? holdHs : inHsync;
      outVsync  <= emit ? holdVs : inVsync;
    end
  end

  // R2: pairs come at most every other cycle
  p_valid_gap_r2: assert property (@(posedge clk) disable iff (rst)
    pairValid |=> !pairValid);

  // R4: quiet data outside pair cycles
  p_blank_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !pairValid |-> (outOdd == '0 && outEven == '0 && !outDe));

  // R8: a lone odd pixel goes out with an empty even slot
  p_partial_even_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.emitPartial |=> (pairValid && outEven == '0));
endmodule

// File: rtl/pix_pair_splitter.sv
module pix_pair_splitter
  import pix_pair_pkg::*;
#(
  parameter int COLOR_W = 8,
  parameter int DROP_W  = 2,
  localparam int PIX_W  = 3 * COLOR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             narrowMode,
  input  logic             inDe,
  input  logic             inHsync,
  input  logic             inVsync,
  input  logic [PIX_W-1:0] inPixel,
  output logic [PIX_W-1:0] outOdd,
  output logic [PIX_W-1:0] outEven,
  output logic             pairValid,
  output logic             outDe,
  output logic             outHsync,
  output logic             outVsync,
  output logic             oddLineErr
);
  pair_ctl_t        ctl;
  logic [PIX_W-1:0] fmtPix;

  pix_fmt #(.COLOR_W(COLOR_W), .DROP_W(DROP_W)) u_fmt (
    .narrow (narrowMode),
    .pixIn  (inPixel),
    .pixOut (fmtPix)
  );

  pair_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inDe       (inDe),
    .ctl        (ctl),
    .oddLineErr (oddLineErr)
  );

  pair_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .pix       (fmtPix),
    .inHsync   (inHsync),
    .inVsync   (inVsync),
    .outOdd    (outOdd),
    .outEven   (outEven),
    .pairValid (pairValid),
    .outDe     (outDe),
    .outHsync  (outHsync),
    .outVsync  (outVsync)
  );

  // R1: the cycle after reset shows no pair and no error
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!pairValid && !oddLineErr && outOdd == '0));
endmodule

// File: tb/pix_pair_splitter_test.sv
module pix_pair_splitter_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        narrowMode = 1'b0;
  logic        inDe = 1'b0;
  logic        inHsync = 1'b0;
  logic        inVsync = 1'b0;
  logic [23:0] inPixel = '0;
  logic [23:0] outOdd, outEven;
  logic        pairValid, outDe, outHsync, outVsync, oddLineErr;

  pix_pair_splitter uut (
    .clk(clk), .rst(rst), .narrowMode(narrowMode), .inDe(inDe),
    .inHsync(inHsync), .inVsync(inVsync), .inPixel(inPixel),
    .outOdd(outOdd), .outEven(outEven), .pairValid(pairValid),
    .outDe(outDe), .outHsync(outHsync), .outVsync(outVsync),
    .oddLineErr(oddLineErr)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference: queue of waiting odd pixels with their syncs
  logic [23:0] pendPix[$];
  logic [1:0]  pendSync[$];
  bit          expErr = 0;
  bit          prevDe = 0;

  function automatic logic [23:0] fmt(bit nm, logic [23:0] p);
    return nm ? {2'b00, p[23:18], 2'b00, p[15:10], 2'b00, p[7:2]} : p;
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; inDe = 0; inHsync = 0; inVsync = 0; inPixel = '0;
    repeat (2) @(posedge clk);
    #1;
    pendPix.delete(); pendSync.delete(); expErr = 0; prevDe = 0;
    check("R1 valid", {23'd0, pairValid}, 24'd0);
    check("R1 odd", outOdd, 24'd0);
    check("R1 even", outEven, 24'd0);
    check("R1 syncs/de", {21'd0, outDe, outHsync, outVsync}, 24'd0);
    check("R1 err", {23'd0, oddLineErr}, 24'd0);
    rst = 1'b0;
  endtask

  task automatic step(bit de, bit hs, bit vs, bit nm, logic [23:0] p);
    logic [23:0] f;
    inDe = de; inHsync = hs; inVsync = vs; narrowMode = nm; inPixel = p;
    @(posedge clk);
    #1;
    f = fmt(nm, p);
    if (de && pendPix.size() == 0) begin
      if (!prevDe) check("R3 line start no pair", {23'd0, pairValid}, 24'd0);
      pendPix.push_back(f);
      pendSync.push_back({hs, vs});
      check("R2 valid low on odd", {23'd0, pairValid}, 24'd0);
      check("R4 quiet", {outOdd, 1'b0} == 0 && outEven == 0 && !outDe ? 24'd1 : 24'd0, 24'd1);
      check("R7 sync pass", {22'd0, outHsync, outVsync}, {22'd0, hs, vs});
    end else if (de) begin
      logic [1:0] sy;
      sy = pendSync.pop_front();
      check("R2 valid", {22'd0, pairValid, outDe}, 24'd3);
      check(nm ? "R6 odd" : "R5 odd", outOdd, pendPix.pop_front());
      check(nm ? "R6 even" : "R5 even", outEven, f);
      check("R7 pair sync", {22'd0, outHsync, outVsync}, {22'd0, sy});
    end else if (pendPix.size() != 0) begin
      logic [1:0] sy;
      sy = pendSync.pop_front();
      expErr = 1;
      check("R8 partial valid", {23'd0, pairValid}, 24'd1);
      check("R8 partial odd", outOdd, pendPix.pop_front());
      check("R8 partial even", outEven, 24'd0);
      check("R8 partial sync", {22'd0, outHsync, outVsync}, {22'd0, sy});
    end else begin
      check("R4 blank valid", {22'd0, pairValid, outDe}, 24'd0);
      check("R4 blank data", outOdd | outEven, 24'd0);
      check("R7 blank sync", {22'd0, outHsync, outVsync}, {22'd0, hs, vs});
    end
    check("R8 err flag", {23'd0, oddLineErr}, {23'd0, expErr});
    prevDe = de;
  endtask

  task automatic line(int len, bit nm, int seed);
    for (int i = 0; i < len; i++)
      step(1, (i % 3) == 1, i == 0, nm, 24'h123456 * (seed + i + 1) ^ 24'hA5C3E1);
  endtask

  task automatic blank(int len);
    for (int i = 0; i < len; i++) step(0, i < 1, 0, 0, 24'hFFFFFF);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    blank(2);
    // R2 R5: even-length full-colour line with known values
    step(1, 1, 0, 0, 24'hFF0080);
    step(1, 0, 1, 0, 24'h01C37E);
    line(6, 0, 3);
    blank(4);
    // R6: narrow mode, including a mode change inside a pair
    line(4, 1, 9);
    step(1, 0, 0, 1, 24'hFFFFFF);
    step(1, 0, 0, 0, 24'hFFFFFF);
    blank(2);
    // R8: odd-length line leaves a lone odd pixel
    line(5, 0, 21);
    blank(2);
    // R3: next line realigns onto the odd slot; error stays set
    line(4, 0, 40);
    blank(2);
    // randomised lines with even blanking
    for (int k = 0; k < 40; k++) begin
      int len;
      len = 1 + ($urandom % 9);
      for (int i = 0; i < len; i++)
        step(1, $urandom % 2, $urandom % 2, $urandom % 2, 24'($urandom));
      blank(2 * (1 + ($urandom % 3)));
    end
    // R1: second reset clears the sticky flag
    doReset();
    line(2, 0, 77);
    blank(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule